// File: doc/BRIEF.md
# Receive Frame Unloader

This block empties one received Ethernet frame from the receive buffer of an external MAC chip. A receive event starts it. It then asks the shared bus arbiter for access and waits until access is granted and the bus sequencer reports that it is ready. After that it pulls the frame out one 16-bit word at a time through the sequencer's auto-incrementing read port.

The first words of the frame form a header. The block reads them and throws them away, with no CRC check. From one header word it takes the frame's byte count, which sets how many payload words follow. Each payload word goes to the user port with a one-cycle valid strobe. After the last word, a one-cycle completion pulse marks the end of the frame, and an interrupt line stays raised until the user clears it. The arbiter request stays high for the whole unload, so no other agent can move the sequencer's read pointer in the middle of a frame.

The controller has four named states:
- `RXU_IDLE` goes to `RXU_ACCESS` on a receive request.
- `RXU_ACCESS` goes to `RXU_HEADER` once grant and ready are both high in the same cycle.
- `RXU_HEADER` goes to `RXU_DATA` after the last header word arrives, or back to `RXU_IDLE` if the payload is empty.
- `RXU_DATA` goes to `RXU_IDLE` after the last payload word.

Top module: `rxu_frame_unloader`

## Requirements
- R1: After reset the block is in `RXU_IDLE`: `bus_req_o`, `seq_rd_o`, `pay_valid_o`, `done_o` and `irq_o` are all 0.
- R2: A high `rx_req_i` in `RXU_IDLE` raises `bus_req_o` from the next cycle. A receive request that arrives while a frame is being unloaded has no effect: no second unload follows.
- R3: No read is issued (`seq_rd_o` stays 0) until `bus_gnt_i` and `seq_ready_i` have been high together in one cycle.
- R4: Exactly HDR_WORDS header words are read (4 by default). None of them appears on the payload port.
- R5: Header word index LEN_IDX (default 1, counted from 0) carries the frame length in bytes. The payload is ceil(length/2) words, and exactly that many payload words are read and presented.
- R6: Each payload word is driven on `pay_data_o` with `pay_valid_o` high for one cycle, in the cycle after its `seq_rvalid_i`. Words come out in read order.
- R7: `done_o` is high for exactly one cycle per frame. It rises in the same cycle as the last payload strobe, or in the cycle after the last header word when the length is 0.
- R8: `bus_req_o` stays high from acceptance of the request until the frame ends. It falls in the same cycle that `done_o` rises.
- R9: At most one read is outstanding: `seq_rd_o` is never high in two consecutive cycles, and no read is issued after the frame's last word has been requested.
- R10: `irq_o` rises together with `done_o` and stays high until `irq_clr_i` is pulsed. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_req_i | input | 1 | Receive event: a frame is waiting in the chip |
| irq_clr_i | input | 1 | Clears the packet-received interrupt |
| bus_req_o | output | 1 | Request to the bus arbiter, held for the whole unload |
| bus_gnt_i | input | 1 | Grant from the arbiter |
| seq_ready_i | input | 1 | Bus sequencer ready for data reads |
| seq_rd_o | output | 1 | One-cycle request for the next auto-incremented word |
| seq_rdata_i | input | LEN_W | Word returned by the sequencer |
| seq_rvalid_i | input | 1 | `seq_rdata_i` holds a returned word |
| pay_data_o | output | LEN_W | Payload word to the user |
| pay_valid_o | output | 1 | One-cycle strobe for `pay_data_o` |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| irq_o | output | 1 | Packet-received interrupt, level |

## Verification
Each internal fault shows up at the ports within one frame. A header counter that is off by one shows up as a wrong first payload value, because a header word leaks through or a payload word is swallowed, and the total number of reads is wrong. A bad length decode or a faulty payload countdown changes the number of strobes, and `done_o` then comes too early or too late against the last strobe. A state that leaves `RXU_ACCESS` before grant, or returns to idle early, shows as a read before grant or as `bus_req_o` falling without `done_o`. The bench sweeps every length from 0 to 9 bytes against sequencer latencies of 1 to 3 cycles, so odd and even lengths and an empty payload are all covered.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
    typedef enum logic [1:0] {
        RXU_IDLE   = 2'd0,
        RXU_ACCESS = 2'd1,
        RXU_HEADER = 2'd2,
        RXU_DATA   = 2'd3
    } rxu_state_e;
endpackage

// File: rtl/rxu_fsm.sv
module rxu_fsm
    import rxu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_req_i,
    input  logic       gnt_i,
    input  logic       ready_i,
    input  logic       hdr_last_i,
    input  logic       pay_zero_i,
    input  logic       pay_last_i,
    output rxu_state_e state_o,
    output logic       finish_o
);
    rxu_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXU_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXU_IDLE:   if (rx_req_i)          state_d = RXU_ACCESS;
            RXU_ACCESS: if (gnt_i && ready_i)  state_d = RXU_HEADER;
            RXU_HEADER: if (hdr_last_i)        state_d = pay_zero_i ? RXU_IDLE : RXU_DATA;
            RXU_DATA:   if (pay_last_i)        state_d = RXU_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state_o  = state_q;
        finish_o = 1'b0;
        unique case (state_q)
            RXU_IDLE:   finish_o = 1'b0;
            RXU_ACCESS: finish_o = 1'b0;
            RXU_HEADER: finish_o = hdr_last_i && pay_zero_i;
            RXU_DATA:   finish_o = pay_last_i;
        endcase
    end

    AST_HDR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RXU_HEADER) && $changed(state_q) |-> $past(gnt_i && ready_i)); // R3
endmodule

// File: rtl/rxu_word_ctr.sv
module rxu_word_ctr
    import rxu_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int HDR_WORDS = 4,
    parameter int LEN_IDX   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rxu_state_e       state_i,
    input  logic             rvalid_i,
    input  logic [LEN_W-1:0] rdata_i,
    output logic             hdr_last_o,
    output logic             pay_zero_o,
    output logic             pay_last_o
);
    localparam int HCW = $clog2(HDR_WORDS + 1);
    localparam logic [HCW-1:0] HDR_LAST = HCW'(HDR_WORDS - 1);
    localparam logic [HCW-1:0] LEN_POS  = HCW'(LEN_IDX);

    logic [HCW-1:0]   hdr_cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] len_now;
    logic [LEN_W:0]   words_wide;
    logic [LEN_W-1:0] words_now;
    logic             hdr_beat;
    logic             pay_beat;

    assign hdr_beat   = (state_i == RXU_HEADER) && rvalid_i;
    assign pay_beat   = (state_i == RXU_DATA) && rvalid_i;
    assign len_now    = (hdr_cnt_q == LEN_POS) ? rdata_i : len_q;
    assign words_wide = ({1'b0, len_now} + {{LEN_W{1'b0}}, 1'b1}) >> 1;
    assign words_now  = words_wide[LEN_W-1:0];

    assign hdr_last_o = hdr_beat && (hdr_cnt_q == HDR_LAST);
    assign pay_zero_o = (words_now == '0);
    assign pay_last_o = pay_beat && (remain_q == LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_cnt_q <= '0;
            len_q     <= '0;
            remain_q  <= '0;
        end else begin
            if (state_i == RXU_IDLE) begin
                hdr_cnt_q <= '0;
            end else if (hdr_beat) begin
                hdr_cnt_q <= hdr_cnt_q + HCW'(1);
                if (hdr_cnt_q == LEN_POS) len_q <= rdata_i;
            end
            if (hdr_last_o)    remain_q <= words_now;
            else if (pay_beat) remain_q <= remain_q - LEN_W'(1);
        end
    end

    AST_DATA_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == RXU_DATA) |-> (remain_q != '0)); // R5
    AST_HDR_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_cnt_q <= HCW'(HDR_WORDS))); // R4
endmodule

// File: rtl/rxu_rd_issuer.sv
module rxu_rd_issuer (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic rvalid_i,
    output logic rd_o
);
    logic pending_q;

    assign rd_o = active_i && !pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pending_q <= 1'b0;
        else if (rd_o)     pending_q <= 1'b1;
        else if (rvalid_i) pending_q <= 1'b0;
    end

    AST_NO_BACK_TO_BACK_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> !rd_o); // R9
    AST_RVALID_ANSWERS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_i |-> pending_q); // R9
endmodule

// File: rtl/rxu_frame_unloader.sv
module rxu_frame_unloader
    import rxu_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int HDR_WORDS = 4,
    parameter int LEN_IDX   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_req_i,
    input  logic             irq_clr_i,
    output logic             bus_req_o,
    input  logic             bus_gnt_i,
    input  logic             seq_ready_i,
    output logic             seq_rd_o,
    input  logic [LEN_W-1:0] seq_rdata_i,
    input  logic             seq_rvalid_i,
    output logic [LEN_W-1:0] pay_data_o,
    output logic             pay_valid_o,
    output logic             done_o,
    output logic             irq_o
);
    rxu_state_e state;
    logic       hdr_last, pay_zero, pay_last, finish, reading;

    rxu_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_req_i   (rx_req_i),
        .gnt_i      (bus_gnt_i),
        .ready_i    (seq_ready_i),
        .hdr_last_i (hdr_last),
        .pay_zero_i (pay_zero),
        .pay_last_i (pay_last),
        .state_o    (state),
        .finish_o   (finish)
    );

    rxu_word_ctr #(
        .LEN_W     (LEN_W),
        .HDR_WORDS (HDR_WORDS),
        .LEN_IDX   (LEN_IDX)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .rvalid_i   (seq_rvalid_i),
        .rdata_i    (seq_rdata_i),
        .hdr_last_o (hdr_last),
        .pay_zero_o (pay_zero),
        .pay_last_o (pay_last)
    );

    assign reading = (state == RXU_HEADER) || (state == RXU_DATA);

    rxu_rd_issuer u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (reading),
        .rvalid_i (seq_rvalid_i),
        .rd_o     (seq_rd_o)
    );

    assign bus_req_o = (state != RXU_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_data_o  <= '0;
            pay_valid_o <= 1'b0;
            done_o      <= 1'b0;
            irq_o       <= 1'b0;
        end else begin
            pay_valid_o <= (state == RXU_DATA) && seq_rvalid_i;
            if ((state == RXU_DATA) && seq_rvalid_i) pay_data_o <= seq_rdata_i;
            done_o <= finish;
            if (finish)         irq_o <= 1'b1;
            else if (irq_clr_i) irq_o <= 1'b0;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_REQ_DROP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_o) |-> done_o); // R8
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> irq_o); // R10
    AST_VALID_FOLLOWS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid_o |-> $past(seq_rvalid_i)); // R6
    AST_NO_RD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_rd_o |-> bus_req_o); // R8
endmodule

// File: tb/rxu_frame_unloader_tb.sv
module rxu_frame_unloader_tb;
    localparam int LW = 16;
    localparam int HW = 4;
    localparam int LI = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_req = 1'b0, irq_clr = 1'b0, gnt = 1'b0, ready = 1'b0;
    logic [LW-1:0] rdata = '0;
    logic rvalid = 1'b0;
    logic bus_req, rd, pay_valid, done, irq;
    logic [LW-1:0] pay_data;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [LW-1:0] mem [0:31];
    int ptr = 0, lat = 1, lat_cnt = 0;

    always #4 clk = ~clk;

    rxu_frame_unloader #(.LEN_W(LW), .HDR_WORDS(HW), .LEN_IDX(LI)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_req_i(rx_req), .irq_clr_i(irq_clr),
        .bus_req_o(bus_req), .bus_gnt_i(gnt), .seq_ready_i(ready),
        .seq_rd_o(rd), .seq_rdata_i(rdata), .seq_rvalid_i(rvalid),
        .pay_data_o(pay_data), .pay_valid_o(pay_valid), .done_o(done), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] pay_word(input int len, input int i);
        return LW'(16'h1200 + len * 37 + i * 3);
    endfunction

    // sequencer model: answers each read after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            rvalid = 1'b0;
            if (lat_cnt != 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    rvalid = 1'b1;
                    rdata  = mem[ptr];
                    ptr++;
                end
            end
            if (rd && rst_n) lat_cnt = lat;
        end
    end

    task automatic run_frame(input int len, input int latency, input int gdelay);
        int words, rd_cnt, pay_cnt, early_rd, cyc;
        bit prev_rd, b2b, req_drop, data_bad, hdr_leak;
        words = (len + 1) / 2;
        for (int i = 0; i < HW; i++) mem[i] = LW'(16'hEE00 + i);
        mem[LI] = LW'(len);
        for (int i = 0; i < words; i++) mem[HW + i] = pay_word(len, i);
        ptr = 0; lat = latency;
        rd_cnt = 0; pay_cnt = 0; early_rd = 0; cyc = 0;
        prev_rd = 0; b2b = 0; req_drop = 0; data_bad = 0; hdr_leak = 0;
        @(negedge clk); rx_req = 1'b1;
        @(negedge clk); rx_req = 1'b0;
        check(bus_req == 1'b1, "R2 request raised", int'(bus_req), 1);
        ready = 1'b1;
        for (int k = 0; k < gdelay; k++) begin
            @(negedge clk);
            if (rd) early_rd++;
        end
        gnt = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            if (rd) rd_cnt++;
            if (rd && prev_rd) b2b = 1;
            prev_rd = rd;
            if (cyc == 3) rx_req = 1'b1;       // R2 request while busy
            if (cyc == 4) rx_req = 1'b0;
            if (pay_valid) begin
                if (pay_data[15:8] == 8'hEE) hdr_leak = 1;
                if (pay_cnt >= words || pay_data != pay_word(len, pay_cnt)) data_bad = 1;
                pay_cnt++;
            end
            if (done) break;
            if (!bus_req) req_drop = 1;
            if (cyc > 300) break;
        end
        rx_req = 1'b0;
        check(done == 1'b1, "R7 done reached", int'(done), 1);
        check(early_rd == 0, "R3 no read before grant", early_rd, 0);
        check(rd_cnt == HW + words, "R4 read count", rd_cnt, HW + words);
        check(pay_cnt == words, "R5 payload count", pay_cnt, words);
        check(!data_bad, "R6 payload values", int'(data_bad), 0);
        check(!hdr_leak, "R4 header not on payload", int'(hdr_leak), 0);
        check(pay_valid == (words > 0), "R7 done with last strobe", int'(pay_valid), int'(words > 0));
        check(!req_drop && !bus_req, "R8 request held then dropped", int'(bus_req), 0);
        check(!b2b, "R9 one outstanding read", int'(b2b), 0);
        check(irq == 1'b1, "R10 irq set", int'(irq), 1);
        gnt = 1'b0; ready = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R7 done one cycle", int'(done), 0);
        rd_cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (rd || bus_req || done) rd_cnt++;
        end
        check(rd_cnt == 0, "R2 busy request ignored / R9 no extra read", rd_cnt, 0);
        check(irq == 1'b1, "R10 irq held", int'(irq), 1);
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check(irq == 1'b0, "R10 irq cleared", int'(irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_req && !rd && !pay_valid && !done && !irq, "R1 reset state",
              int'({bus_req, rd, pay_valid, done, irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !rd && !irq, "R1 idle after reset", int'({bus_req, rd, irq}), 0);
        for (int len = 0; len < 10; len++)
            for (int l = 1; l <= 3; l++)
                run_frame(len, l, (len + l) % 4);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule